// File: doc/BRIEF.md
# Wraparound Timer with Compare Interrupt

This block keeps a free-running 32-bit count of time units. A programmable prescaler divides the clock down to a time-unit tick, and each tick advances the count by one. The count wraps from the all-ones value back to zero. A compare register holds a target time. Software arms a delay by writing the target as the current count plus a delay of less than 2^31 units, using unsigned addition that wraps.

Whether the target has been reached is decided by a modular test: the compare register is subtracted from the timer over 32 bits, and the target counts as reached when bit 31 of the difference is zero. Because of this, a target that lies beyond the wrap point stays unreached until the count has wrapped and caught up. The interrupt request is a level. It is the compare status gated by a mask bit. The request goes away only when the compare register is rewritten to a value ahead of the timer. The mask comes out of reset set, so interrupts start out disabled. The mask affects only the request line and leaves counting and comparing alone.

One write port loads all of the registers. A 2-bit select chooses the target of each write.

Top module: `wrap_timer`

## Requirements
- R1: Each prescaler tick adds one to `timerValue`, wrapping modulo 2^32. Without a tick or a timer write, `timerValue` holds its value.
- R2: The prescaler ticks once every P+1 clock cycles, where P is the reload value written with `wrSel`=0 (low 16 bits of `wrData`). Such a write restarts the count, and the first tick comes P+1 cycles after it. P is 0 after reset, so after reset the timer advances on every cycle.
- R3: A write with `wrSel`=1 loads `timerValue` from `wrData` on that clock edge. The write takes priority over any tick on the same edge.
- R4: A write with `wrSel`=2 loads the compare register. `cmpReached` is 1 exactly when bit 31 of (timer − compare), taken modulo 2^32, is 0. At both boundaries, a difference of 0x7FFFFFFF gives 1 and a difference of 0x80000000 gives 0.
- R5: `irq` equals `cmpReached` AND NOT mask on every cycle. It is a level, not a pulse, and it stays high while both conditions hold.
- R6: Once `irq` is high, it falls only when a compare write places the target ahead of the timer. The timer continuing to count does not clear it.
- R7: The mask is bit 0 of a write with `wrSel`=3. It is 1 after reset, so `irq` is 0 after reset even though `cmpReached` is 1 (timer and compare are both 0).
- R8: While the mask is 1, counting and `cmpReached` behave exactly as they do with the mask at 0.
- R9: With timer 0xFFFFFF00 and compare 0xFFFFFF00+0x3E8=0x000002E8, `irq` stays 0 through the wrap and first rises when `timerValue` reaches 0x000002E8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 prescaler reload, 1 timer, 2 compare, 3 mask |
| wrData | input | 32 | Write data |
| timerValue | output | 32 | Current timer count |
| cmpReached | output | 1 | Timer at or past compare value (modular test) |
| irq | output | 1 | Level interrupt request, gated by mask |

## Verification
A wrong prescaler count or reload appears on `timerValue` at the first tick that is missing or arrives early. That is at most P+1 cycles after the fault, so the bench tracks every cycle for a sweep of reload values. A corrupted timer or compare register shows on `cmpReached` in the same cycle when the fault moves the difference across bit 31. The bench therefore places compare values one unit on each side of both boundaries, zero and 2^31. A mask that is stuck or resets wrongly shows on `irq` in the first cycle after reset, and again on every cycle of the long wrap run.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;

  typedef enum logic [1:0] {
    SEL_PRESCALE = 2'd0,
    SEL_TIMER    = 2'd1,
    SEL_COMPARE  = 2'd2,
    SEL_MASK     = 2'd3
  } regSel_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadTmr;
    logic loadCmp;
    logic loadMask;
    logic tick;
  } ctlStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import wrap_timer_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [PW-1:0] preData,
  output ctlStrobe_t    strobes
);

  logic [PW-1:0] preReload;
  logic [PW-1:0] preCnt;
  regSel_e       selE;
  logic          loadPre;
  logic          cntZero;

  assign selE    = regSel_e'(wrSel);
  assign loadPre = wrEn && (selE == SEL_PRESCALE);
  assign cntZero = (preCnt == '0);

  always_comb begin
    strobes.loadTmr  = wrEn && (selE == SEL_TIMER);
    strobes.loadCmp  = wrEn && (selE == SEL_COMPARE);
    strobes.loadMask = wrEn && (selE == SEL_MASK);
    strobes.tick     = cntZero && !loadPre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preReload <= '0;
      preCnt    <= '0;
    end else if (loadPre) begin
      preReload <= preData;
      preCnt    <= preData;
    end else if (cntZero) begin
      preCnt    <= preReload;
    end else begin
      preCnt    <= preCnt - 1'b1;
    end
  end

endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import wrap_timer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStrobe_t    strobes,
  input  logic [TW-1:0] wrData,
  output logic [TW-1:0] timerValue,
  output logic          cmpReached,
  output logic          irq
);

  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] tmrQ;
  logic [TW-1:0] cmpQ;
  logic          maskQ;
  logic [TW-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrQ <= '0;
    end else if (strobes.loadTmr) begin
      tmrQ <= wrData;
    end else if (strobes.tick) begin
      tmrQ <= tmrQ + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpQ  <= '0;
      maskQ <= 1'b1;
    end else begin
      if (strobes.loadCmp)  cmpQ  <= wrData;
      if (strobes.loadMask) maskQ <= wrData[0];
    end
  end

  // Modular test: only the top bit of the difference matters
  assign diff       = tmrQ - cmpQ;
  assign cmpReached = ~diff[TW-1];
  assign irq        = cmpReached & ~maskQ;
  assign timerValue = tmrQ;

endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wrap_timer_pkg::*;
#(
  parameter int TW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [TW-1:0] wrData,
  output logic [TW-1:0] timerValue,
  output logic          cmpReached,
  output logic          irq
);

  ctlStrobe_t strobes;

  timer_ctrl #(.PW(PW)) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .preData (wrData[PW-1:0]),
    .strobes (strobes)
  );

  timer_dp #(.TW(TW)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .wrData     (wrData),
    .timerValue (timerValue),
    .cmpReached (cmpReached),
    .irq        (irq)
  );

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrEn,
  input logic [1:0]    wrSel,
  input logic [TW-1:0] wrData,
  input logic [TW-1:0] timerValue,
  input logic          cmpReached,
  input logic          irq,
  input logic          tick,
  input logic          maskQ
);

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wrEn && wrSel == 2'd1)) |=> (timerValue == $past(timerValue) + TW'(1))); // R1

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wrEn && wrSel == 2'd1)) |=> $stable(timerValue)); // R1

  AST_RELOAD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel == 2'd0) |-> !tick); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel == 2'd1) |=> (timerValue == $past(wrData))); // R3

  AST_REACH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !tick) |=> $stable(cmpReached)); // R4

  AST_IRQ_NEEDS_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmpReached); // R5

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    maskQ |-> !irq); // R7

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && wrSel == 2'd3) |=> $stable(maskQ)); // R7

endmodule

bind wrap_timer timer_chk #(.TW(TW)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .timerValue (timerValue),
  .cmpReached (cmpReached),
  .irq        (irq),
  .tick       (strobes.tick),
  .maskQ      (uDp.maskQ)
);

// File: tb/sim_wrap_timer.sv
`timescale 1ns/1ps
module sim_wrap_timer;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [TW-1:0] wrData = '0;
  logic [TW-1:0] timerValue;
  logic          cmpReached;
  logic          irq;

  int checks = 0;
  int failures = 0;

  // Expected state, advanced from the requirement text
  logic [15:0]   mRel = '0;
  logic [15:0]   mCnt = '0;
  logic [TW-1:0] mTr = '0;
  logic [TW-1:0] mTcr = '0;
  logic          mMask = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrap_timer u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .timerValue(timerValue), .cmpReached(cmpReached), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      logic tk;
      tk = 1'b0;
      if (wrEn && wrSel == 2'd0) begin
        mRel <= wrData[15:0];
        mCnt <= wrData[15:0];
      end else if (mCnt == 16'd0) begin
        tk = 1'b1;
        mCnt <= mRel;
      end else begin
        mCnt <= mCnt - 16'd1;
      end
      if (wrEn && wrSel == 2'd1) mTr <= wrData;
      else if (tk) mTr <= mTr + 32'd1;
      if (wrEn && wrSel == 2'd2) mTcr <= wrData;
      if (wrEn && wrSel == 2'd3) mMask <= wrData[0];
    end
  end

  function automatic logic expReached(input logic [TW-1:0] t, input logic [TW-1:0] c);
    logic [TW-1:0] d;
    d = t - c;
    return (d < 32'h8000_0000);
  endfunction

  task automatic chk1(input string tag, input string what, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    logic er;
    er = expReached(mTr, mTcr);
    chk1(tag, "timerValue", timerValue, mTr);
    chk1(tag, "cmpReached", {31'd0, cmpReached}, {31'd0, er});
    chk1(tag, "irq", {31'd0, irq}, {31'd0, er & ~mMask});
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [TW-1:0] d, input string tag);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d;
    @(posedge clk);
    #2;
    checkAll(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [TW-1:0] base;
    int firstIrqSeen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7: after reset mask set, compare reached but request low
    chk1("R7", "reset cmpReached", {31'd0, cmpReached}, 32'd1);
    chk1("R7", "reset irq", {31'd0, irq}, 32'd0);
    chk1("R1", "reset timer", timerValue, 32'd0);

    // R2 / R1: reload 0 after reset, ticks each cycle
    idle(5, "R2");

    // R2: sweep reload values, checking every cycle
    for (int p = 0; p <= 6; p++) begin
      step(1'b1, 2'd0, TW'(p), "R2");
      idle(3 * (p + 1) + 2, "R2");
    end

    // R3: timer write while a tick lands on the same edge
    step(1'b1, 2'd0, 32'd0, "R3");
    step(1'b1, 2'd1, 32'h1234_5678, "R3");
    chk1("R3", "loaded value", timerValue, 32'h1234_5678);
    idle(3, "R3");
    step(1'b1, 2'd1, 32'hFFFF_FFFE, "R1");
    idle(4, "R1"); // wraps through zero

    // R4: boundaries of the modular test, timer frozen by long reload
    step(1'b1, 2'd0, 32'h0000_FFFF, "R4");
    step(1'b1, 2'd1, 32'h1000_0000, "R4");
    base = 32'h1000_0000;
    step(1'b1, 2'd2, base + 32'h7FFF_FFFF, "R4");
    chk1("R4", "diff 0x80000001", {31'd0, cmpReached}, 32'd0);
    step(1'b1, 2'd2, base - 32'h7FFF_FFFF, "R4");
    chk1("R4", "diff 0x7FFFFFFF", {31'd0, cmpReached}, 32'd1);
    step(1'b1, 2'd2, base - 32'h8000_0000, "R4");
    chk1("R4", "diff 0x80000000", {31'd0, cmpReached}, 32'd0);
    step(1'b1, 2'd2, base, "R4");
    chk1("R4", "diff 0", {31'd0, cmpReached}, 32'd1);
    step(1'b1, 2'd2, base + 32'd1, "R4");
    chk1("R4", "diff -1", {31'd0, cmpReached}, 32'd0);

    // R8: masked, compare keeps working as timer counts past target
    step(1'b1, 2'd0, 32'd1, "R8");
    step(1'b1, 2'd2, base + 32'd5, "R8");
    idle(20, "R8");
    chk1("R8", "reached while masked", {31'd0, cmpReached}, 32'd1);
    chk1("R8", "irq masked", {31'd0, irq}, 32'd0);

    // R5: unmask, request follows level
    step(1'b1, 2'd3, 32'd0, "R5");
    chk1("R5", "irq unmasked", {31'd0, irq}, 32'd1);
    // R6: timer counting does not clear the request
    idle(40, "R6");
    chk1("R6", "irq held", {31'd0, irq}, 32'd1);
    step(1'b1, 2'd3, 32'd1, "R5");
    chk1("R5", "irq remasked", {31'd0, irq}, 32'd0);
    step(1'b1, 2'd3, 32'd0, "R5");
    // R6: rewrite compare ahead of timer
    step(1'b1, 2'd2, timerValue + 32'd100, "R6");
    chk1("R6", "irq cleared", {31'd0, irq}, 32'd0);
    idle(10, "R6");

    // R9: delay across the wrap point
    step(1'b1, 2'd0, 32'd0, "R9");
    step(1'b1, 2'd1, 32'hFFFF_FF00, "R9");
    step(1'b1, 2'd2, 32'hFFFF_FF00 + 32'h0000_03E8, "R9");
    chk1("R9", "compare value", mTcr, 32'h0000_02E8);
    firstIrqSeen = 0;
    for (int i = 0; i < 1010; i++) begin
      step(1'b0, 2'd0, '0, "R9");
      if (irq && firstIrqSeen == 0) begin
        firstIrqSeen = 1;
        chk1("R9", "timer at first irq", timerValue, 32'h0000_02E8);
      end
    end
    chk1("R9", "irq seen", TW'(firstIrqSeen), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule